// File: doc/BRIEF.md
# Preemptive Interrupt Priority Selector

This block looks at a set of interrupt lines that are already enabled and pending, each with its own programmable 8-bit priority. It picks the one that should be offered to the processor core next. A smaller priority number means a more urgent interrupt. Only the upper five bits of each priority byte are implemented. A grouping control divides those bits into a preempt part and a subpriority part.

When no handler is running, the most urgent eligible request is offered. When a handler is running, a request is offered only if its preempt part is strictly more urgent than that of the running handler. Two global controls can hold requests back. A disable bit blocks everything. A threshold register blocks every request whose priority number is at or above the threshold. The outputs are registered, so they reflect the inputs sampled at the previous clock edge.

The block is a control and status path with no data stream, so all of its pins are plain levels with no valid/ready handshake. `req_valid` is a level meaning "the core should take `req_id` now". The core is expected to raise `active_valid` and load `active_prio` once it enters the handler.

Top module: `irq_prio_select`

## Requirements
- R1: Among eligible requests, the one with the numerically smallest implemented priority is offered on `req_id`, with that priority on `req_prio`.
- R2: Bits [2:0] of every priority byte, of `active_prio` and of `prio_thresh` are ignored in all comparisons. `req_prio` always has bits [2:0] equal to zero.
- R3: With `group_sel` = g, the preempt part is priority bits [7:g+1] and the subpriority part is bits [g:0]. Values g = 0..2 make all five implemented bits preempt bits. g = 7 makes the preempt part empty, so a running handler is never preempted.
- R4: While `active_valid` is 1, a request is offered only if its preempt part is numerically strictly less than the preempt part of `active_prio`. If the preempt parts are equal, the request waits.
- R5: Among requests with equal preempt parts, the smaller subpriority is offered first. A smaller subpriority alone never preempts a running handler.
- R6: When both the preempt part and the subpriority are equal, the lower interrupt number wins.
- R7: While `global_dis` is 1, `req_valid` is 0 on the next cycle.
- R8: When the implemented bits of `prio_thresh` are nonzero, any request with priority greater than or equal to the threshold is not eligible. A threshold of zero blocks nothing.
- R9: Outputs are registered with one cycle of latency. During reset, and in any cycle with `req_valid` = 0, `req_id` and `req_prio` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pending | input | 32 | Enabled-and-pending flag per interrupt |
| irq_prio | input | 32x8 | Priority byte per interrupt (packed, index = interrupt number) |
| group_sel | input | 3 | Split point between preempt part and subpriority |
| active_valid | input | 1 | A handler is currently running |
| active_prio | input | 8 | Priority of the running handler |
| global_dis | input | 1 | Block all requests |
| prio_thresh | input | 8 | Priority threshold mask (0 = off) |
| req_valid | output | 1 | A request should be taken |
| req_id | output | 5 | Winning interrupt number |
| req_prio | output | 8 | Winning priority (bits [2:0] zero) |

## Verification
On every cycle, the embedded assertions check several output properties:
- The disable bit silences the output.
- An offered priority lies below a nonzero threshold and beats the running handler's preempt part.
- The offered interrupt was pending.
- The low priority bits read as zero, and idle outputs are zero.

Which request wins an ordering contest can only be shown by the bench's scenarios and its behavioural model. This covers the smallest value, the subpriority order inside one preempt level, the lowest-number tie-break and the effect of each grouping setting.

// File: rtl/ips_pkg.sv
package ips_pkg;
  localparam int unsigned IPS_NUM_IRQ   = 32;
  localparam int unsigned IPS_PRIO_W    = 8;
  localparam int unsigned IPS_IMPL_BITS = 5;

  // Bits strictly above the group point, limited to the field width.
  function automatic logic [31:0] upper_mask(input int unsigned width,
                                             input int unsigned g);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if ((b < width) && (b > g)) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ips_eligibility.sv
module ips_eligibility
  import ips_pkg::*;
#(
  parameter int unsigned N_IRQ     = IPS_NUM_IRQ,
  parameter int unsigned PRIO_W    = IPS_PRIO_W,
  parameter int unsigned IMPL_BITS = IPS_IMPL_BITS
) (
  input  logic [N_IRQ-1:0]             pending,
  input  logic [N_IRQ-1:0][PRIO_W-1:0] prio,
  input  logic                         global_dis,
  input  logic [PRIO_W-1:0]            thresh,
  output logic [N_IRQ-1:0]             elig,
  output logic [N_IRQ-1:0][PRIO_W-1:0] prio_m
);
  localparam logic [PRIO_W-1:0] LOW_ONES  = PRIO_W'((1 << (PRIO_W - IMPL_BITS)) - 1);
  localparam logic [PRIO_W-1:0] IMPL_MASK = ~LOW_ONES;

  logic [PRIO_W-1:0] th_m;
  logic              th_on;

  assign th_m  = thresh & IMPL_MASK;
  assign th_on = (th_m != '0);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign prio_m[i] = prio[i] & IMPL_MASK;
    assign elig[i]   = pending[i] & ~global_dis & (~th_on | (prio_m[i] < th_m));
  end
endmodule

// File: rtl/ips_min_tree.sv
module ips_min_tree
  import ips_pkg::*;
#(
  parameter int unsigned N_IRQ  = IPS_NUM_IRQ,
  parameter int unsigned PRIO_W = IPS_PRIO_W,
  parameter int unsigned IDW    = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]             cand_v,
  input  logic [N_IRQ-1:0][PRIO_W-1:0] cand_p,
  output logic                         win_v,
  output logic [IDW-1:0]               win_id,
  output logic [PRIO_W-1:0]            win_p
);
  localparam int unsigned LVLS = $clog2(N_IRQ);
  localparam int unsigned PAD  = 1 << LVLS;

  // Heap layout: node k has children 2k and 2k+1; leaves PAD..2*PAD-1.
  logic              nv  [1:2*PAD-1];
  logic [PRIO_W-1:0] np  [1:2*PAD-1];
  logic [IDW-1:0]    nid [1:2*PAD-1];

  for (genvar j = 0; j < PAD; j++) begin : g_leaf
    if (j < N_IRQ) begin : g_real
      assign nv[PAD+j]  = cand_v[j];
      assign np[PAD+j]  = cand_p[j];
      assign nid[PAD+j] = IDW'(j);
    end else begin : g_pad
      assign nv[PAD+j]  = 1'b0;
      assign np[PAD+j]  = '0;
      assign nid[PAD+j] = '0;
    end
  end

  // Left child holds lower numbers, so it keeps ties.
  for (genvar k = 1; k < PAD; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+1] & (~nv[2*k] | (np[2*k+1] < np[2*k]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign np[k]  = take_r ? np[2*k+1]  : np[2*k];
    assign nid[k] = take_r ? nid[2*k+1] : nid[2*k];
  end

  assign win_v  = nv[1];
  assign win_id = nid[1];
  assign win_p  = np[1];
endmodule

// File: rtl/ips_preempt_gate.sv
module ips_preempt_gate
  import ips_pkg::*;
#(
  parameter int unsigned PRIO_W    = IPS_PRIO_W,
  parameter int unsigned IMPL_BITS = IPS_IMPL_BITS,
  parameter int unsigned GRP_W     = $clog2(PRIO_W)
) (
  input  logic              win_v,
  input  logic [PRIO_W-1:0] win_p,
  input  logic [GRP_W-1:0]  group_sel,
  input  logic              active_valid,
  input  logic [PRIO_W-1:0] active_prio,
  output logic              grant
);
  localparam logic [PRIO_W-1:0] LOW_ONES  = PRIO_W'((1 << (PRIO_W - IMPL_BITS)) - 1);
  localparam logic [PRIO_W-1:0] IMPL_MASK = ~LOW_ONES;

  logic [PRIO_W-1:0] pre_mask;
  logic [PRIO_W-1:0] win_pre;
  logic [PRIO_W-1:0] act_pre;

  assign pre_mask = PRIO_W'(upper_mask(PRIO_W, 32'(group_sel))) & IMPL_MASK;
  assign win_pre  = win_p & pre_mask;
  assign act_pre  = active_prio & pre_mask;
  assign grant    = win_v & (~active_valid | (win_pre < act_pre));
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import ips_pkg::*;
#(
  parameter int unsigned N_IRQ     = IPS_NUM_IRQ,
  parameter int unsigned PRIO_W    = IPS_PRIO_W,
  parameter int unsigned IMPL_BITS = IPS_IMPL_BITS,
  localparam int unsigned IDW      = $clog2(N_IRQ),
  localparam int unsigned GRP_W    = $clog2(PRIO_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IRQ-1:0]             irq_pending,
  input  logic [N_IRQ-1:0][PRIO_W-1:0] irq_prio,
  input  logic [GRP_W-1:0]             group_sel,
  input  logic                         active_valid,
  input  logic [PRIO_W-1:0]            active_prio,
  input  logic                         global_dis,
  input  logic [PRIO_W-1:0]            prio_thresh,
  output logic                         req_valid,
  output logic [IDW-1:0]               req_id,
  output logic [PRIO_W-1:0]            req_prio
);
  localparam logic [PRIO_W-1:0] LOW_ONES  = PRIO_W'((1 << (PRIO_W - IMPL_BITS)) - 1);
  localparam logic [PRIO_W-1:0] IMPL_MASK = ~LOW_ONES;

  logic [N_IRQ-1:0]             elig;
  logic [N_IRQ-1:0][PRIO_W-1:0] prio_m;
  logic                         win_v;
  logic [IDW-1:0]               win_id;
  logic [PRIO_W-1:0]            win_p;
  logic                         grant;

  ips_eligibility #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS)) u_elig (
    .pending(irq_pending), .prio(irq_prio), .global_dis(global_dis),
    .thresh(prio_thresh), .elig(elig), .prio_m(prio_m)
  );

  ips_min_tree #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .IDW(IDW)) u_tree (
    .cand_v(elig), .cand_p(prio_m), .win_v(win_v), .win_id(win_id), .win_p(win_p)
  );

  ips_preempt_gate #(.PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS), .GRP_W(GRP_W)) u_gate (
    .win_v(win_v), .win_p(win_p), .group_sel(group_sel),
    .active_valid(active_valid), .active_prio(active_prio), .grant(grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_id    <= '0;
      req_prio  <= '0;
    end else begin
      req_valid <= grant;
      req_id    <= grant ? win_id : '0;
      req_prio  <= grant ? win_p  : '0;
    end
  end

  // Preempt mask recomputed here from the group control, for checking only.
  logic [PRIO_W-1:0] chk_pm;
  assign chk_pm = PRIO_W'(upper_mask(PRIO_W, 32'(group_sel))) & IMPL_MASK;

  assert_gdis_R7: assert property (@(posedge clk) disable iff (!rst_n)
    global_dis |=> !req_valid);

  assert_thresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((prio_thresh & IMPL_MASK) != '0) |=>
      (!req_valid || (req_prio < ($past(prio_thresh) & IMPL_MASK))));

  assert_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_valid |=>
      (!req_valid || ((req_prio & $past(chk_pm)) <
                      ($past(active_prio) & $past(chk_pm)))));

  assert_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((($past(irq_pending) >> req_id) & N_IRQ'(1)) != '0));

  assert_lowbits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prio & LOW_ONES) == '0);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_id == '0 && req_prio == '0));
endmodule

// File: tb/irq_prio_select_tb.sv
`timescale 1ns/1ps
module irq_prio_select_tb;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      irq_pending = '0;
  logic [31:0][7:0] irq_prio = '0;
  logic [2:0]       group_sel = '0;
  logic             active_valid = 1'b0;
  logic [7:0]       active_prio = '0;
  logic             global_dis = 1'b0;
  logic [7:0]       prio_thresh = '0;
  logic             req_valid;
  logic [4:0]       req_id;
  logic [7:0]       req_prio;

  int errors = 0;
  int checks = 0;
  bit exp_v;
  int exp_id, exp_p;

  always #4 clk = ~clk;

  irq_prio_select u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_prio(irq_prio),
    .group_sel(group_sel), .active_valid(active_valid), .active_prio(active_prio),
    .global_dis(global_dis), .prio_thresh(prio_thresh),
    .req_valid(req_valid), .req_id(req_id), .req_prio(req_prio)
  );

  // Behavioural reference built from the requirements.
  task automatic model();
    int best, bp, th, pm, pre;
    best = -1; bp = 0;
    th = int'(prio_thresh) & 248;
    for (int i = 0; i < 32; i++) begin
      if (irq_pending[i] && !global_dis) begin
        pm = int'(irq_prio[i]) & 248;
        if (!(th != 0 && pm >= th)) begin
          if (best < 0 || pm < bp) begin best = i; bp = pm; end
        end
      end
    end
    if (best >= 0 && active_valid) begin
      pre = (255 << (int'(group_sel) + 1)) & 248;
      if (!((bp & pre) < (int'(active_prio) & 248 & pre))) best = -1;
    end
    exp_v  = (best >= 0);
    exp_id = exp_v ? best : 0;
    exp_p  = exp_v ? bp : 0;
  endtask

  task automatic check(string tag);
    checks++;
    if (req_valid !== exp_v || int'(req_id) != exp_id || int'(req_prio) != exp_p) begin
      errors++;
      $display("FAIL %s: got v=%0b id=%0d p=%02h, expected v=%0b id=%0d p=%02h",
               tag, req_valid, req_id, req_prio, exp_v, exp_id, exp_p);
    end
  endtask

  // Inputs are set just after a falling edge; result is checked one cycle later.
  task automatic step(string tag);
    model();
    @(negedge clk);
    check(tag);
  endtask

  task automatic clear_all();
    irq_pending = '0; irq_prio = '0; group_sel = '0; active_valid = 1'b0;
    active_prio = '0; global_dis = 1'b0; prio_thresh = '0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R9: reset state, inputs already requesting
    irq_pending = 32'h1; irq_prio[0] = 8'h10;
    @(negedge clk); @(negedge clk);
    exp_v = 0; exp_id = 0; exp_p = 0;
    check("R9 reset");
    rst_n = 1'b1;
    clear_all();
    step("R9 idle");

    // R1: smallest value wins
    irq_pending = (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20);
    irq_prio[3] = 8'h40; irq_prio[7] = 8'h20; irq_prio[20] = 8'h80;
    step("R1 min");
    irq_prio[20] = 8'h08;
    step("R1 min changed");

    // R2: low bits ignored
    clear_all();
    irq_pending = (32'h1 << 2) | (32'h1 << 4);
    irq_prio[2] = 8'h27; irq_prio[4] = 8'h21;
    step("R2 low bits");

    // R6: full tie -> lowest number
    clear_all();
    irq_pending = (32'h1 << 9) | (32'h1 << 5) | (32'h1 << 31);
    irq_prio[9] = 8'h60; irq_prio[5] = 8'h60; irq_prio[31] = 8'h60;
    step("R6 tie");

    // R7: global disable
    global_dis = 1'b1;
    step("R7 disable");
    global_dis = 1'b0;
    step("R7 re-enable");

    // R8: threshold
    clear_all();
    irq_pending = (32'h1 << 1) | (32'h1 << 2);
    irq_prio[1] = 8'h40; irq_prio[2] = 8'h48; prio_thresh = 8'h40;
    step("R8 at/above thresh");
    irq_pending[3] = 1'b1; irq_prio[3] = 8'h38;
    step("R8 below thresh");
    prio_thresh = 8'h05;
    step("R8 thresh low bits only");
    prio_thresh = 8'h00;
    step("R8 thresh off");

    // R4: strict preemption, all bits preempt
    clear_all();
    group_sel = 3'd2; active_valid = 1'b1; active_prio = 8'h40;
    irq_pending = 32'h1 << 6; irq_prio[6] = 8'h40;
    step("R4 equal waits");
    irq_prio[6] = 8'h38;
    step("R4 more urgent");
    irq_prio[6] = 8'h48;
    step("R4 less urgent");

    // R3/R5: group point 4 -> preempt bits [7:5], sub [4:3]
    clear_all();
    group_sel = 3'd4; active_valid = 1'b1; active_prio = 8'h40;
    irq_pending = 32'h1 << 10; irq_prio[10] = 8'h58;
    step("R5 sub no preempt");
    irq_prio[10] = 8'h20;
    step("R3 preempt group 4");
    active_valid = 1'b0;
    irq_pending = (32'h1 << 10) | (32'h1 << 11);
    irq_prio[10] = 8'h58; irq_prio[11] = 8'h48;
    step("R5 sub order");
    active_valid = 1'b1; active_prio = 8'h58;
    step("R5 sub vs active");

    // R3: group 7 -> never preempt
    clear_all();
    group_sel = 3'd7; active_valid = 1'b1; active_prio = 8'hF8;
    irq_pending = 32'h1; irq_prio[0] = 8'h00;
    step("R3 group 7");
    group_sel = 3'd0;
    step("R3 group 0");

    // Random mix compared with the model on every clock
    for (int n = 0; n < 4000; n++) begin
      irq_pending = $urandom() & $urandom();
      for (int i = 0; i < 32; i++) irq_prio[i] = 8'($urandom());
      group_sel    = 3'($urandom());
      active_valid = ($urandom() % 2) == 0;
      active_prio  = 8'($urandom());
      global_dis   = ($urandom() % 10) == 0;
      prio_thresh  = (($urandom() % 4) == 0) ? 8'h00 : 8'($urandom());
      step("R1 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule